// File: doc/BRIEF.md
# Dual Shiftable Window Correlator

This block scores stereo matches for a streamed scanline using two movable correlation windows in place of one delay tap per disparity. Each cycle that carries a pixel delivers one complex left sample and one complex right sample, both filter outputs. The right samples are kept in a circular partial line buffer. It holds just enough columns to reach the largest disparity, so both windows can reach any offset in the range. Each window covers nine neighbouring disparities and yields nine correlation scores per pixel. A score is the real part of the left sample times the conjugate of the right sample found that many columns to the left.

The primary window follows the scene over time. For every pixel it is centred on the disparity that pixel had in the previous frame, and that value arrives on an input alongside the pixel. The secondary window sweeps a fixed schedule, moving once per frame, so that it picks up matches the primary window has lost. A join input places the secondary window directly after the primary one, and the two then act as a single window 18 offsets wide. Normalisation, smoothing and peak search happen downstream.

Top module: `dual_window_correlator`

## Requirements
- R1: For a pixel at column x and an in-range offset d, the score equals left_re*right_re + left_im*right_im, where the right sample comes from column x-d. Both samples are signed 16-bit values and the score is 33-bit signed. A window's offset k (0..8) is disparity centre-4+k and occupies score bits [33k+32:33k].
- R2: For each pixel, pri_centre equals that pixel's prev_disp.
- R3: The roving centre is 0 after reset and changes only on a frame_start cycle. At that cycle the limit is rove_max clamped to MAX_DISP. A centre of 0 moves to ROVE_START (10). A centre at or above the limit moves to 0. Any other centre moves to the smaller of centre+rove_step and the limit.
- R4: rove_step and rove_max are sampled only on frame_start cycles. Their values at other times have no effect on the roving centre.
- R5: While join_en is 1 for a pixel, sec_centre is prev_disp+9, so the two windows cover 18 consecutive disparities.
- R6: An offset is treated as out of range when its disparity is below 0, above the pixel's column, or above MAX_DISP. For such an offset the ok bit is 0 and the score is 0. For every other offset the ok bit is 1.
- R7: A pixel presented with in_valid before clock edge n appears on both windows' outputs, with valid high, after edge n+1. Valid is low in every cycle that does not carry such a result.
- R8: line_start or frame_start restarts the column count, so the next pixel is column 0 and earlier lines are never used as matches.
- R9: The buffer keeps MAX_DISP+1 right samples. On lines longer than the buffer, offsets up to MAX_DISP still correlate against the correct column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame strobe: advances the roving centre and restarts the column |
| line_start | input | 1 | Line strobe: restarts the column |
| in_valid | input | 1 | A pixel is present this cycle |
| left_re | input | SW | Left sample, real part (signed) |
| left_im | input | SW | Left sample, imaginary part (signed) |
| right_re | input | SW | Right sample, real part (signed) |
| right_im | input | SW | Right sample, imaginary part (signed) |
| prev_disp | input | DW | Previous-frame disparity of this pixel |
| join_en | input | 1 | Place the secondary window right after the primary one |
| rove_step | input | DW | Roving increment, sampled at frame_start |
| rove_max | input | DW | Roving limit, sampled at frame_start |
| pri_valid | output | 1 | Primary window result valid |
| pri_centre | output | CW | Primary window centre disparity |
| pri_score | output | WIN*SCW | Primary scores, offset k at bits [SCW*k +: SCW] |
| pri_ok | output | WIN | Primary per-offset in-range flags |
| sec_valid | output | 1 | Secondary window result valid |
| sec_centre | output | CW | Secondary window centre disparity |
| sec_score | output | WIN*SCW | Secondary scores |
| sec_ok | output | WIN | Secondary per-offset in-range flags |

## Verification
A pixel is registered at the edge where it is presented, together with its right-sample write. Its scores are registered at the following edge, so every result is due two clock edges after the pixel is driven. The bench drives a new pixel at each falling edge and, in the same falling edge and before driving, checks the pixel it drove two falling edges earlier. That keeps every comparison in step with the pipeline while the input streams without gaps. Rover updates take effect at the strobe edge and are observed through sec_centre on the pixels that follow. Valid is checked low again once the line has drained.

// File: rtl/dual_window_correlator.sv
module dual_window_correlator #(
  parameter int SW = 16,
  parameter int WIN = 9,
  parameter int MAX_DISP = 128,
  parameter int ROVE_START = 10,
  parameter int COL_W = 11,
  localparam int DW = $clog2(MAX_DISP + 1),
  localparam int CW = $clog2(MAX_DISP + WIN + 1),
  localparam int SCW = 2 * SW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  line_start,
  input  logic                  in_valid,
  input  logic signed [SW-1:0]  left_re,
  input  logic signed [SW-1:0]  left_im,
  input  logic signed [SW-1:0]  right_re,
  input  logic signed [SW-1:0]  right_im,
  input  logic [DW-1:0]         prev_disp,
  input  logic                  join_en,
  input  logic [DW-1:0]         rove_step,
  input  logic [DW-1:0]         rove_max,
  output logic                  pri_valid,
  output logic [CW-1:0]         pri_centre,
  output logic [WIN*SCW-1:0]    pri_score,
  output logic [WIN-1:0]        pri_ok,
  output logic                  sec_valid,
  output logic [CW-1:0]         sec_centre,
  output logic [WIN*SCW-1:0]    sec_score,
  output logic [WIN-1:0]        sec_ok
);
  localparam int BUF = MAX_DISP + 1;
  localparam int AW = $clog2(BUF);
  localparam int HALF = WIN / 2;

  logic [2*SW-1:0] mem [BUF];
  logic [AW-1:0] wptr, p1;
  logic [COL_W-1:0] col, col1;
  logic [DW-1:0] rove_pos, rove_next, lim;
  logic [DW:0] sum;
  logic v1, v2;
  logic signed [SW-1:0] l_re1, l_im1;
  logic [CW-1:0] cen1 [2];
  logic [CW-1:0] cen2 [2];
  logic signed [SCW-1:0] sc_n [2][WIN];
  logic signed [SCW-1:0] sc_q [2][WIN];
  logic [WIN-1:0] ok_n [2];
  logic [WIN-1:0] ok_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      col <= '0;
    end else if (frame_start || line_start) begin
      wptr <= '0;
      col <= '0;
    end else if (in_valid) begin
      wptr <= (int'(wptr) == BUF - 1) ? '0 : wptr + 1'b1;
      col <= (col == '1) ? col : col + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (in_valid) mem[wptr] <= {right_re, right_im};

  always_comb begin
    lim = (int'(rove_max) > MAX_DISP) ? DW'(MAX_DISP) : rove_max;
    sum = {1'b0, rove_pos} + {1'b0, rove_step};
    if (rove_pos == '0) rove_next = DW'(ROVE_START);
    else if (rove_pos >= lim) rove_next = '0;
    else if (sum > {1'b0, lim}) rove_next = lim;
    else rove_next = sum[DW-1:0];
  end

  always_ff @(posedge clk)
    if (!rst_n) rove_pos <= '0;
    else if (frame_start) rove_pos <= rove_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      l_re1 <= '0;
      l_im1 <= '0;
      p1 <= '0;
      col1 <= '0;
      cen1[0] <= '0;
      cen1[1] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        l_re1 <= left_re;
        l_im1 <= left_im;
        p1 <= wptr;
        col1 <= col;
        cen1[0] <= CW'(prev_disp);
        cen1[1] <= join_en ? CW'(prev_disp) + CW'(WIN) : CW'(rove_pos);
      end
    end
  end

  always_comb begin
    int d, t;
    logic ok;
    logic [AW-1:0] idx;
    logic signed [SW-1:0] rr, ri;
    logic signed [2*SW-1:0] pr, pi;
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < WIN; k++) begin
        d = int'(cen1[w]) + k - HALF;
        ok = (d >= 0) && (d <= int'(col1)) && (d <= MAX_DISP);
        t = int'(p1) - d;
        if (t < 0) t = t + BUF;
        idx = ok ? AW'(t) : '0;
        {rr, ri} = mem[idx];
        pr = l_re1 * rr;
        pi = l_im1 * ri;
        ok_n[w][k] = ok;
        sc_n[w][k] = ok ? SCW'(pr) + SCW'(pi) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      for (int w = 0; w < 2; w++) begin
        ok_q[w] <= '0;
        cen2[w] <= '0;
        for (int k = 0; k < WIN; k++) sc_q[w][k] <= '0;
      end
    end else begin
      v2 <= v1;
      for (int w = 0; w < 2; w++) begin
        ok_q[w] <= ok_n[w];
        cen2[w] <= cen1[w];
        for (int k = 0; k < WIN; k++) sc_q[w][k] <= sc_n[w][k];
      end
    end
  end

  for (genvar k = 0; k < WIN; k++) begin : g_pack
    assign pri_score[k*SCW +: SCW] = sc_q[0][k];
    assign sec_score[k*SCW +: SCW] = sc_q[1][k];
  end

  assign pri_valid = v2;
  assign sec_valid = v2;
  assign pri_centre = cen2[0];
  assign sec_centre = cen2[1];
  assign pri_ok = ok_q[0];
  assign sec_ok = ok_q[1];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 (pri_valid && sec_valid)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> ##2 !pri_valid); // R7
  AST_ROVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_start |=> $stable(rove_pos)); // R4
  AST_ROVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> (int'(rove_pos) <= MAX_DISP)); // R3
  AST_PRI_CENTRE: assert property (@(posedge clk) disable iff (!rst_n) pri_valid |-> (pri_centre == CW'($past(prev_disp, 2)))); // R2
  AST_JOINED: assert property (@(posedge clk) disable iff (!rst_n) (pri_valid && $past(join_en, 2)) |-> (sec_centre == pri_centre + CW'(WIN))); // R5
endmodule

// File: tb/dual_window_correlator_tb.sv
module dual_window_correlator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int WIN = 9;
  localparam int MAXD = 20;
  localparam int START = 10;
  localparam int COLW = 6;
  localparam int DW = $clog2(MAXD + 1);
  localparam int CW = $clog2(MAXD + WIN + 1);
  localparam int SCW = 2 * SW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, line_start = 1'b0, in_valid = 1'b0, join_en = 1'b0;
  logic signed [SW-1:0] left_re = '0, left_im = '0, right_re = '0, right_im = '0;
  logic [DW-1:0] prev_disp = '0, rove_step = '0, rove_max = '0;
  logic pri_valid, sec_valid;
  logic [CW-1:0] pri_centre, sec_centre;
  logic [WIN*SCW-1:0] pri_score, sec_score;
  logic [WIN-1:0] pri_ok, sec_ok;

  int checks = 0, errors = 0, cycles = 0;
  int rpos = 0;
  int l_re[64], l_im[64], r_re[64], r_im[64], pd[64], sce[64], jn[64];
  string line_tag = "R1";

  dual_window_correlator #(.SW(SW), .WIN(WIN), .MAX_DISP(MAXD), .ROVE_START(START), .COL_W(COLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start), .in_valid(in_valid),
    .left_re(left_re), .left_im(left_im), .right_re(right_re), .right_im(right_im),
    .prev_disp(prev_disp), .join_en(join_en), .rove_step(rove_step), .rove_max(rove_max),
    .pri_valid(pri_valid), .pri_centre(pri_centre), .pri_score(pri_score), .pri_ok(pri_ok),
    .sec_valid(sec_valid), .sec_centre(sec_centre), .sec_score(sec_score), .sec_ok(sec_ok));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(bit good, string req, string what, longint act, longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int smp(int f, int c, int salt);
    int v;
    if (f == 0 && c == 0) return -32768;
    v = (c * 7919 + f * 3571 + salt * 911 + c * c * 13) % 65536;
    return v - 32768;
  endfunction

  task automatic check_pix(int i);
    for (int w = 0; w < 2; w++) begin
      int ce, ac, d, bad;
      logic [WIN-1:0] okx, oka;
      longint e, a, bad_a, bad_e;
      ce = (w == 0) ? pd[i] : sce[i];
      ac = (w == 0) ? int'(pri_centre) : int'(sec_centre);
      chk((w == 0) ? pri_valid : sec_valid, "R7", "valid", 0, 1);
      chk(ac == ce, (w == 0) ? "R2" : (jn[i] != 0 ? "R5" : "R3"), "centre", ac, ce);
      bad = 0; bad_a = 0; bad_e = 0;
      oka = (w == 0) ? pri_ok : sec_ok;
      for (int k = 0; k < WIN; k++) begin
        d = ce + k - WIN / 2;
        okx[k] = (d >= 0 && d <= i && d <= MAXD);
        e = okx[k] ? longint'(l_re[i]) * r_re[i - d] + longint'(l_im[i]) * r_im[i - d] : 0;
        a = (w == 0) ? longint'($signed(pri_score[k*SCW +: SCW])) : longint'($signed(sec_score[k*SCW +: SCW]));
        if (a != e && bad == 0) begin bad = 1; bad_a = a; bad_e = e; end
      end
      chk(oka == okx, "R6", "ok mask", longint'(oka), longint'(okx));
      chk(bad == 0, line_tag, "score", bad_a, bad_e);
    end
  endtask

  task automatic run_line(int f, int len, int j);
    for (int n = 0; n < len + 2; n++) begin
      @(negedge clk);
      if (n >= 2) check_pix(n - 2);
      if (n < len) begin
        l_re[n] = smp(f, n, 1); l_im[n] = smp(f, n, 2);
        r_re[n] = smp(f, n, 3); r_im[n] = smp(f, n, 4);
        pd[n] = (n * 5 + f * 3) % (MAXD + 1);
        if (n == 3) pd[n] = MAXD;
        if (n == 4) pd[n] = 0;
        jn[n] = j;
        sce[n] = (j != 0) ? pd[n] + WIN : rpos;
        in_valid = 1'b1; join_en = (j != 0);
        left_re = SW'(l_re[n]); left_im = SW'(l_im[n]);
        right_re = SW'(r_re[n]); right_im = SW'(r_im[n]);
        prev_disp = DW'(pd[n]);
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    chk(!pri_valid && !sec_valid, "R7", "valid after drain", longint'(pri_valid), 0);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pri_valid && !sec_valid, "R7", "valid in reset", longint'(pri_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pri_valid, "R7", "valid after reset", longint'(pri_valid), 0);
    line_tag = "R1";
    run_line(0, 3, 0);
    chk(rpos == 0, "R3", "model start", rpos, 0);
    for (int f = 0; f < 10; f++) begin
      int stp, mx, lm;
      stp = (f < 5) ? 4 : 7;
      mx = (f < 5) ? 20 : ((f == 7) ? 31 : 13);
      @(negedge clk);
      frame_start = 1'b1; rove_step = DW'(stp); rove_max = DW'(mx);
      lm = (mx > MAXD) ? MAXD : mx;
      if (rpos == 0) rpos = START;
      else if (rpos >= lm) rpos = 0;
      else rpos = (rpos + stp > lm) ? lm : rpos + stp;
      @(negedge clk);
      frame_start = 1'b0; rove_step = DW'(1); rove_max = DW'(2);
      line_tag = "R1 R9";
      run_line(f + 1, 30, (f == 2 || f == 7) ? 1 : 0);
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
      line_tag = "R8";
      run_line(f + 101, 12, (f == 4) ? 1 : 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule